// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the per-channel registers of a descriptor-driven DMA engine. Software reaches it over a 32-bit word-addressed register bus. Each channel gets a 128-byte window that holds sixteen word registers. The most important register is the channel status word. Software never writes it bit by bit. It sends a control write that carries its own 16-bit enable mask in the upper half and the new bit values in the lower half. The block merges the enabled bits into status. It then derives the busy flag and the failure flag from the result, using fixed priority rules.

A descriptor sequencer sits next to the bank, one per channel. It reads the run, flush, wake and busy indications. It receives a one-cycle start request whenever a control write leaves the channel busy. It also reads the current descriptor pointer. In the other direction the sequencer reports two events: a failure (kill), which marks the channel failed and pulses its interrupt, and a halt (stop), which leaves the channel idle. While the channel is running or busy, the descriptor pointer cannot be changed.

Top module: `dchan_csr_bank`

## Requirements
- R1: After reset, every stored register of every channel reads 0. The outputs seq_run_o, seq_flush_o, seq_wake_o, seq_active_o, seq_start_o, irq_o and cmdptr_o are also 0.
- R2: A write to register index 0 (control) uses bits 31:16 as the mask and bits 15:0 as the value. Only value bits 15 (RUN), 14 (PAUSE), 13 (FLUSH), 12 (WAKE) and 7:0 (device status) can be set. For each masked bit, the status bit takes the value bit, and a masked bit outside that set becomes 0. Unmasked status bits keep their value.
- R3: After the merge, WAKE=1 sets ACTIVE (bit 10). RUN=1 sets ACTIVE and clears DEAD (bit 11). PAUSE=1 then clears ACTIVE, so PAUSE wins.
- R4: A control write that changes RUN from 1 to 0 clears both ACTIVE and DEAD.
- R5: A write to index 3 (descriptor pointer) is ignored while RUN or ACTIVE is 1. An accepted write stores the data with bits 3:0 forced to 0.
- R6: Reads of index 0 and of indices 2, 7, 8, 9, 11 and 12 return 0. Indices 3, 4, 5, 6, 10, 13, 14 and 15 return the last stored word. A write to index 1 replaces the 16-bit status word with data bits 15:0, and a read of index 1 returns the status zero-extended to 32 bits.
- R7: A kill event sets DEAD, clears ACTIVE and drives irq_o high for exactly one cycle. Kill is applied after a write and after a stop in the same cycle.
- R8: A stop event that comes without a kill clears ACTIVE and DEAD and leaves every other status bit unchanged.
- R9: seq_start_o pulses high for one cycle right after a control write whose final status has ACTIVE=1. It stays low after any other write.
- R10: The channel is selected by address bits above bit 6, and the register index by address bits 5:2. Address bit 6 is ignored. A write changes only the addressed channel.
- R11: bus_rdata_o shows the addressed register one cycle after bus_rd_i and holds its value in cycles without a read.
- R12: seq_run_o, seq_flush_o, seq_wake_o and seq_active_o always equal status bits 15, 13, 12 and 10 of their channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address: channel in bits above 6, index in bits 5:2 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| seq_kill_i | input | NUM_CH | Per-channel failure event from the sequencer |
| seq_stop_i | input | NUM_CH | Per-channel halt event from the sequencer |
| seq_run_o | output | NUM_CH | RUN bit per channel |
| seq_flush_o | output | NUM_CH | FLUSH bit per channel |
| seq_wake_o | output | NUM_CH | WAKE bit per channel |
| seq_active_o | output | NUM_CH | ACTIVE bit per channel |
| seq_start_o | output | NUM_CH | One-cycle start request per channel |
| irq_o | output | NUM_CH | One-cycle interrupt pulse per channel |
| cmdptr_o | output | 32*NUM_CH | Descriptor pointer per channel |

## Verification
The assertions check these properties on every cycle:
- The descriptor pointer holds while a write to it is blocked, and its low nibble stays clear.
- PAUSE keeps ACTIVE low after any control write.
- A control write that drops RUN leaves the channel neither busy nor failed.
- A kill or stop event leaves status in the required state.
- A start or interrupt pulse appears only when its cause was present.
- Read data holds while there is no read.

Some behaviours only the bench scenarios can show. These are the exact status word after each mask-and-value merge, including the case where masked-in DEAD and ACTIVE bits are dropped. The bench scenarios also cover the zero readback of unimplemented indices, isolation between channels, the ignored address bit 6, and the ordering when a kill and a control write land in the same cycle.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    localparam int ST_RUN   = 15;
    localparam int ST_PAUSE = 14;
    localparam int ST_FLUSH = 13;
    localparam int ST_WAKE  = 12;
    localparam int ST_DEAD  = 11;
    localparam int ST_ACT   = 10;

    // value bits a control write may apply
    localparam logic [15:0] CTL_WRITABLE = 16'hF0FF;

    localparam logic [3:0] IX_CTL   = 4'd0;
    localparam logic [3:0] IX_STAT  = 4'd1;
    localparam logic [3:0] IX_CPHI  = 4'd2;
    localparam logic [3:0] IX_CPLO  = 4'd3;
    localparam logic [3:0] IX_ISEL  = 4'd4;
    localparam logic [3:0] IX_BSEL  = 4'd5;
    localparam logic [3:0] IX_WSEL  = 4'd6;
    localparam logic [3:0] IX_XMODE = 4'd7;
    localparam logic [3:0] IX_D2HI  = 4'd8;
    localparam logic [3:0] IX_D2LO  = 4'd9;
    localparam logic [3:0] IX_SPA   = 4'd10;
    localparam logic [3:0] IX_ADHI  = 4'd11;
    localparam logic [3:0] IX_BRHI  = 4'd12;
    localparam logic [3:0] IX_SPB   = 4'd13;
    localparam logic [3:0] IX_SPC   = 4'd14;
    localparam logic [3:0] IX_SPD   = 4'd15;

    localparam int N_SPARE = 4;

    typedef struct packed {
        logic [15:0]               status;
        logic [31:0]               cmdptr;
        logic [31:0]               isel;
        logic [31:0]               bsel;
        logic [31:0]               wsel;
        logic [N_SPARE-1:0][31:0]  spare;
        logic                      start;
        logic                      irq;
    } chan_state_t;

    // Mask-and-value merge followed by derived-flag priority rules.
    function automatic logic [15:0] ctl_merge(input logic [15:0] old_st,
                                              input logic [31:0] wr);
        logic [15:0] msk;
        logic [15:0] val;
        logic [15:0] nst;
        msk = wr[31:16];
        val = wr[15:0] & CTL_WRITABLE;
        nst = (val & msk) | (old_st & ~msk);
        if (nst[ST_WAKE]) nst[ST_ACT] = 1'b1;
        if (nst[ST_RUN]) begin
            nst[ST_ACT]  = 1'b1;
            nst[ST_DEAD] = 1'b0;
        end
        if (nst[ST_PAUSE]) nst[ST_ACT] = 1'b0;
        if (old_st[ST_RUN] && !nst[ST_RUN]) begin
            nst[ST_ACT]  = 1'b0;
            nst[ST_DEAD] = 1'b0;
        end
        return nst;
    endfunction

endpackage

// File: rtl/dchan_addr_dec.sv
module dchan_addr_dec #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 9,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic [CH_W-1:0]   chan_o,
    output logic [3:0]        idx_o,
    output logic [NUM_CH-1:0] wr_sel_o
);
    // bit 6 and bits 1:0 take no part in decoding
    assign idx_o = addr_i[5:2];

    generate
        if (NUM_CH > 1) begin : g_multi
            assign chan_o = addr_i[7 +: CH_W];
        end else begin : g_single
            assign chan_o = '0;
        end
    endgenerate

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign wr_sel_o[c] = wr_i && (chan_o == CH_W'(c));
    end

endmodule

// File: rtl/dchan_chan.sv
module dchan_chan
    import dchan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [3:0]  idx_i,
    input  logic [31:0] wdata_i,
    input  logic        kill_i,
    input  logic        stop_i,
    output logic [31:0] rd_word_o,
    output logic [15:0] status_o,
    output logic [31:0] cmdptr_o,
    output logic        start_o,
    output logic        irq_o
);
    chan_state_t st_d, st_q;
    logic        ctl_wr;
    logic        busy_q;
    logic [15:0] nst;

    assign ctl_wr = wr_i && (idx_i == IX_CTL);
    assign busy_q = st_q.status[ST_RUN] || st_q.status[ST_ACT];

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.irq   = 1'b0;
        nst        = st_q.status;
        if (wr_i) begin
            case (idx_i)
                IX_CTL:  nst = ctl_merge(st_q.status, wdata_i);
                IX_STAT: nst = wdata_i[15:0];
                IX_CPLO: if (!busy_q) st_d.cmdptr = {wdata_i[31:4], 4'b0000};
                IX_ISEL: st_d.isel = wdata_i;
                IX_BSEL: st_d.bsel = wdata_i;
                IX_WSEL: st_d.wsel = wdata_i;
                IX_SPA:  st_d.spare[0] = wdata_i;
                IX_SPB:  st_d.spare[1] = wdata_i;
                IX_SPC:  st_d.spare[2] = wdata_i;
                IX_SPD:  st_d.spare[3] = wdata_i;
                default: ;
            endcase
        end
        if (stop_i) begin
            nst[ST_ACT]  = 1'b0;
            nst[ST_DEAD] = 1'b0;
        end
        if (kill_i) begin
            nst[ST_DEAD] = 1'b1;
            nst[ST_ACT]  = 1'b0;
            st_d.irq     = 1'b1;
        end
        st_d.status = nst;
        st_d.start  = ctl_wr && nst[ST_ACT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (idx_i)
            IX_STAT: rd_word_o = {16'h0000, st_q.status};
            IX_CPLO: rd_word_o = st_q.cmdptr;
            IX_ISEL: rd_word_o = st_q.isel;
            IX_BSEL: rd_word_o = st_q.bsel;
            IX_WSEL: rd_word_o = st_q.wsel;
            IX_SPA:  rd_word_o = st_q.spare[0];
            IX_SPB:  rd_word_o = st_q.spare[1];
            IX_SPC:  rd_word_o = st_q.spare[2];
            IX_SPD:  rd_word_o = st_q.spare[3];
            default: rd_word_o = 32'h0;
        endcase
    end

    assign status_o = st_q.status;
    assign cmdptr_o = st_q.cmdptr;
    assign start_o  = st_q.start;
    assign irq_o    = st_q.irq;

    assert_cmdptr_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && idx_i == IX_CPLO && busy_q) |=> $stable(cmdptr_o));

    assert_cmdptr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmdptr_o[3:0] == 4'b0000);

    assert_pause_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !(status_o[ST_PAUSE] && status_o[ST_ACT]));

    assert_run_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && status_o[ST_RUN] && !kill_i)
        |=> (status_o[ST_RUN] || (!status_o[ST_ACT] && !status_o[ST_DEAD])));

    assert_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (status_o[ST_DEAD] && !status_o[ST_ACT] && irq_o));

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !kill_i |=> !irq_o);

    assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !kill_i) |=> (!status_o[ST_ACT] && !status_o[ST_DEAD]));

    assert_start_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> status_o[ST_ACT]);

    assert_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> !start_o);

endmodule

// File: rtl/dchan_csr_bank.sv
module dchan_csr_bank
    import dchan_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = $clog2(NUM_CH) + 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    input  logic [NUM_CH-1:0]    seq_kill_i,
    input  logic [NUM_CH-1:0]    seq_stop_i,
    output logic [NUM_CH-1:0]    seq_run_o,
    output logic [NUM_CH-1:0]    seq_flush_o,
    output logic [NUM_CH-1:0]    seq_wake_o,
    output logic [NUM_CH-1:0]    seq_active_o,
    output logic [NUM_CH-1:0]    seq_start_o,
    output logic [NUM_CH-1:0]    irq_o,
    output logic [32*NUM_CH-1:0] cmdptr_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0]         chan;
    logic [3:0]              idx;
    logic [NUM_CH-1:0]       wr_sel;
    logic [NUM_CH-1:0][31:0] rd_words;
    logic [31:0]             rdata_d, rdata_q;

    dchan_addr_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) u_dec (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .chan_o   (chan),
        .idx_o    (idx),
        .wr_sel_o (wr_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [15:0] status;
        dchan_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_sel[c]),
            .idx_i     (idx),
            .wdata_i   (bus_wdata_i),
            .kill_i    (seq_kill_i[c]),
            .stop_i    (seq_stop_i[c]),
            .rd_word_o (rd_words[c]),
            .status_o  (status),
            .cmdptr_o  (cmdptr_o[32*c +: 32]),
            .start_o   (seq_start_o[c]),
            .irq_o     (irq_o[c])
        );
        assign seq_run_o[c]    = status[ST_RUN];
        assign seq_flush_o[c]  = status[ST_FLUSH];
        assign seq_wake_o[c]   = status[ST_WAKE];
        assign seq_active_o[c] = status[ST_ACT];
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd_i) begin
            rdata_d = 32'h0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (chan == CH_W'(c)) rdata_d = rd_words[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata_o = rdata_q;

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

// File: tb/dchan_csr_bank_bench.sv
module dchan_csr_bank_bench;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 9;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_wr = 1'b0;
    logic                 bus_rd = 1'b0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NUM_CH-1:0]    kill = '0;
    logic [NUM_CH-1:0]    stop = '0;
    logic [NUM_CH-1:0]    run, flush, wake, active, start, irq;
    logic [32*NUM_CH-1:0] cmdptr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dchan_csr_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dchan_csr_bank (
        .clk (clk), .rst_n (rst_n),
        .bus_wr_i (bus_wr), .bus_rd_i (bus_rd), .bus_addr_i (bus_addr),
        .bus_wdata_i (bus_wdata), .bus_rdata_o (bus_rdata),
        .seq_kill_i (kill), .seq_stop_i (stop),
        .seq_run_o (run), .seq_flush_o (flush), .seq_wake_o (wake),
        .seq_active_o (active), .seq_start_o (start), .irq_o (irq),
        .cmdptr_o (cmdptr)
    );

    // control-write stimulus on channel 0 and expected status afterwards
    localparam logic [31:0] VEC_W [0:8] = '{
        32'h8000_8000, 32'h4000_4000, 32'h4000_0000, 32'h00FF_005A,
        32'h8000_0000, 32'h1000_1000, 32'h1F00_0F00, 32'h2000_2000,
        32'hFFFF_0000 };
    localparam logic [15:0] VEC_S [0:8] = '{
        16'h8400, 16'hC000, 16'h8400, 16'h845A,
        16'h005A, 16'h145A, 16'h005A, 16'h205A,
        16'h0000 };

    function automatic logic [ADDR_W-1:0] ra(input int ch, input int ix);
        return ADDR_W'((ch << 7) | (ix << 2));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < NUM_CH; c++) begin
            rd(ra(c, 1), v); chk("R1 status", v, 32'h0);
            rd(ra(c, 3), v); chk("R1 cmdptr", v, 32'h0);
            rd(ra(c, 4), v); chk("R1 isel", v, 32'h0);
        end
        chk("R1 outputs", {26'h0, run | flush | wake | active | start | irq}, 32'h0);
        chk("R1 cmdptr_o", cmdptr[31:0] | cmdptr[127:96], 32'h0);

        // R2 R3 R4 R12 table of control writes
        for (int i = 0; i < 9; i++) begin
            wr(ra(0, 0), VEC_W[i]);
            chk("R9 start follows active", {31'h0, start[0]}, {31'h0, VEC_S[i][10]});
            rd(ra(0, 1), v);
            chk("R2/R3/R4 status merge", v, {16'h0, VEC_S[i]});
            chk("R12 flags", {28'h0, run[0], flush[0], wake[0], active[0]},
                {28'h0, VEC_S[i][15], VEC_S[i][13], VEC_S[i][12], VEC_S[i][10]});
        end

        // R5 aligned descriptor pointer write when idle
        wr(ra(1, 3), 32'h1234_567F);
        rd(ra(1, 3), v); chk("R5 align", v, 32'h1234_5670);
        chk("R5 cmdptr_o", cmdptr[63:32], 32'h1234_5670);

        // R7 kill
        @(negedge clk) kill[1] = 1'b1;
        @(posedge clk); #1 kill[1] = 1'b0;
        chk("R7 irq pulse", {31'h0, irq[1]}, 32'h1);
        @(posedge clk); #1;
        chk("R7 irq one cycle", {31'h0, irq[1]}, 32'h0);
        rd(ra(1, 1), v); chk("R7 dead set", v, 32'h0800);

        // R3 RUN clears DEAD, R9 start
        wr(ra(1, 0), 32'h8000_8000);
        chk("R9 start pulse", {31'h0, start[1]}, 32'h1);
        @(posedge clk); #1;
        chk("R9 start one cycle", {31'h0, start[1]}, 32'h0);
        rd(ra(1, 1), v); chk("R3 run clears dead", v, 32'h8400);

        // R5 pointer locked while running
        wr(ra(1, 3), 32'hAAAA_AAA0);
        rd(ra(1, 3), v); chk("R5 locked run", v, 32'h1234_5670);

        // R8 stop
        @(negedge clk) stop[1] = 1'b1;
        @(posedge clk); #1 stop[1] = 1'b0;
        rd(ra(1, 1), v); chk("R8 stop", v, 32'h8000);
        wr(ra(1, 3), 32'hBBBB_BBB0);
        rd(ra(1, 3), v); chk("R5 locked by run bit", v, 32'h1234_5670);

        // R4 run fall, then pointer accepted
        wr(ra(1, 0), 32'h8000_0000);
        chk("R9 no start when idle", {31'h0, start[1]}, 32'h0);
        rd(ra(1, 1), v); chk("R4 run fall", v, 32'h0);
        wr(ra(1, 3), 32'h0000_0F0F);
        rd(ra(1, 3), v); chk("R5 accepted", v, 32'h0000_0F00);

        // R6 direct status write, then R5 lock by ACTIVE alone
        wr(ra(1, 1), 32'hDEAD_0401);
        rd(ra(1, 1), v); chk("R6 status write", v, 32'h0000_0401);
        wr(ra(1, 3), 32'h5555_5550);
        rd(ra(1, 3), v); chk("R5 locked active", v, 32'h0000_0F00);
        wr(ra(1, 1), 32'h0);

        // R6 readback rules
        wr(ra(2, 0), 32'h0000_0001);
        rd(ra(2, 0), v); chk("R6 control reads zero", v, 32'h0);
        foreach (VEC_S[k]) begin
            int ixs [6] = '{2, 7, 8, 9, 11, 12};
            if (k < 6) begin
                wr(ra(2, ixs[k]), 32'hFFFF_FFFF);
                rd(ra(2, ixs[k]), v); chk("R6 unimplemented zero", v, 32'h0);
            end
        end
        begin
            int ixk [7] = '{4, 5, 6, 10, 13, 14, 15};
            for (int k = 0; k < 7; k++) wr(ra(2, ixk[k]), 32'hC0DE_0000 + k);
            for (int k = 0; k < 7; k++) begin
                rd(ra(2, ixk[k]), v); chk("R6 stored readback", v, 32'hC0DE_0000 + k);
            end
        end

        // R10 bit 6 ignored, isolation
        wr(ra(3, 4) | ADDR_W'(64), 32'h0BAD_F00D);
        rd(ra(3, 4), v); chk("R10 bit6 ignored", v, 32'h0BAD_F00D);
        rd(ra(2, 4), v); chk("R10 isolation", v, 32'hC0DE_0000);
        wr(ra(3, 0), 32'h8000_8000);
        chk("R10 run only ch3", {28'h0, run}, 32'h8);

        // R7 kill wins over same-cycle control write
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ra(3, 0); bus_wdata = 32'h1000_1000; kill[3] = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; kill[3] = 1'b0;
        chk("R7 kill beats write start", {31'h0, start[3]}, 32'h0);
        rd(ra(3, 1), v); chk("R7 kill beats write", v, 32'h9800);

        // R11 hold
        @(posedge clk); #1;
        chk("R11 rdata hold", bus_rdata, 32'h9800);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule